// File: doc/BRIEF.md
# Receive Character Queue with Idle Aging

This block sits behind a serial receiver's deserializer and buffers the characters it produces. Every character is stored together with the flags the receiver reports for it: framing error, parity error and break. A fourth flag marks an overrun. The queue holds 32 entries by default. It presents the oldest entry on its read port without a read request, and a one-cycle read strobe removes that entry.

Three sticky status sources can request service. The fill-level source fires when the stored count reaches a programmable high-water threshold. The aging source fires when characters are waiting but no character has arrived for eight character periods. Without it, a short burst below the threshold would wait in the queue with no request. The break source fires whenever a character flagged as a break arrives. Each source has its own enable, software clears each one by writing 1 to it, and the interrupt line is the OR of the enabled sources.

Top module: `uart_rx_agefifo`

## Requirements
- R1: After reset the queue is empty: `data_ready`, `status`, `irq` and `rd_word` are all 0.
- R2: Entries leave in arrival order. `rd_word` shows the oldest entry with the data byte in bits 7:0, framing error in bit 8, parity error in bit 9, overrun in bit 10 and break in bit 11. `rd_en` removes that entry. A read strobe while the queue is empty does nothing, and `rd_word` reads 0 while the queue is empty.
- R3: The queue holds DEPTH characters (32). A character that arrives while the queue is full is discarded, and the overrun bit (bit 10) is set on the newest stored entry. No other entry changes.
- R4: `data_ready` is 1 whenever at least one entry is stored, whatever the threshold.
- R5: Status bit 0 (fill level) is set one cycle after the stored count becomes greater than or equal to `hiwater`. A threshold of 0 never sets it.
- R6: Status bit 1 (aging) is set on the eighth `char_tick` that falls while the queue is non-empty and no character has arrived and no read has taken place. Any arriving character or accepted read restarts the count. The count does not run while the queue is empty. After it has fired once, the count does not fire again until it is restarted.
- R7: Status bit 2 (break) is set on the cycle a character with its break flag arrives, including a character that is discarded.
- R8: A cycle with `stat_clr_wr` high clears every status bit whose `stat_clr` bit is 1 and leaves the others unchanged. A set condition in the same cycle takes priority over the clear.
- R9: `irq` is 1 exactly when some status bit is 1 together with its own enable (`ien_ready` for bit 0, `ien_age` for bit 1, `ien_brk` for bit 2). The break source does not depend on the other two enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | 8 | Received character |
| chr_frm_err | input | 1 | Framing error for this character |
| chr_par_err | input | 1 | Parity error for this character |
| chr_brk | input | 1 | Character is a break condition |
| char_tick | input | 1 | One pulse per character period |
| rd_en | input | 1 | Remove the oldest entry |
| hiwater | input | 6 | Fill threshold for status bit 0; 0 disables that source |
| ien_ready | input | 1 | Enable of the fill-level source |
| ien_age | input | 1 | Enable of the aging source |
| ien_brk | input | 1 | Enable of the break source |
| stat_clr_wr | input | 1 | Write strobe for the clear mask |
| stat_clr | input | 3 | Write-1-to-clear mask: bit 0 fill level, bit 1 aging, bit 2 break |
| rd_word | output | 12 | Oldest entry: flags in bits 11:8 and data in bits 7:0 |
| data_ready | output | 1 | At least one entry is stored |
| status | output | 3 | Sticky status: bit 0 fill level, bit 1 aging, bit 2 break |
| irq | output | 1 | Service request |

## Verification
The design captures a character on the rising edge where `chr_valid` is high. That same edge updates `rd_word`, `data_ready`, the break status, the aging status (on the expiring tick) and an overrun mark. The fill-level status is one edge later, because it is derived from the registered count. `irq` follows the status and the enables without a register. The bench changes inputs only on falling edges and holds each strobe for exactly one cycle. It samples at the falling edge after the capturing edge, and for the fill-level status it waits one more falling edge. Scoreboard comparisons are made on the entry shown before the read strobe that removes it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int CHAR_W = 8;

  // One stored character with its per-character flags (bit order is the read-word layout)
  typedef struct packed {
    logic              brk;
    logic              ovr;
    logic              par;
    logic              frm;
    logic [CHAR_W-1:0] data;
  } rxq_entry_t;

  localparam int ENTRY_W = $bits(rxq_entry_t);

  // Status sources
  localparam int NSRC      = 3;
  localparam int SRC_READY = 0;
  localparam int SRC_AGE   = 1;
  localparam int SRC_BRK   = 2;

  // Circular pointer step for a ring of lim slots
  function automatic logic [31:0] wrap_inc(input logic [31:0] p, input logic [31:0] lim);
    return (p == lim - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

  function automatic logic [31:0] wrap_dec(input logic [31:0] p, input logic [31:0] lim);
    return (p == 32'd0) ? lim - 32'd1 : p - 32'd1;
  endfunction

  // Fill-level condition; a zero threshold switches the source off
  function automatic logic thr_reached(input logic [31:0] cnt, input logic [31:0] thr);
    return (thr != 32'd0) && (cnt >= thr);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rxq_entry_t    wr_entry,
  input  logic          pop,
  output rxq_entry_t    rd_entry,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty,
  output logic          push_acc,
  output logic          pop_acc
);

  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] last_ptr;
  logic [CW-1:0] fill_q;

  assign fill     = fill_q;
  assign full     = (fill_q == CW'(DEPTH));
  assign empty    = (fill_q == '0);
  assign push_acc = push & ~full;
  assign pop_acc  = pop & ~empty;
  assign last_ptr = AW'(wrap_dec(32'(wr_ptr), DEPTH));
  assign rd_entry = empty ? '0 : mem[rd_ptr];

  // Storage: a new entry, or an overrun mark on the newest one when full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_acc) begin
      mem[wr_ptr] <= wr_entry;
    end else if (push && full) begin
      mem[last_ptr].ovr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_acc) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (pop_acc)  rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else begin
      case ({push_acc, pop_acc})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

endmodule

// File: rtl/rxq_age.sv
module rxq_age #(
  parameter  int LIMIT = 8,
  localparam int GW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic restart,
  input  logic active,
  output logic expire
);

  localparam logic [GW-1:0] LIM  = GW'(LIMIT);
  localparam logic [GW-1:0] LAST = GW'(LIMIT - 1);

  logic [GW-1:0] cnt_q;

  // Fires once on the tick that completes LIMIT quiet periods
  assign expire = active & ~restart & tick & (cnt_q == LAST);

  // Saturates at LIM so a stale queue raises the event only once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || restart) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ien,
  output logic [N-1:0] status,
  output logic         irq
);

  logic [N-1:0] st_q;

  for (genvar gi = 0; gi < N; gi++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[gi] <= 1'b0;
      end else if (set[gi]) begin
        st_q[gi] <= 1'b1;
      end else if (clr_wr && clr_mask[gi]) begin
        st_q[gi] <= 1'b0;
      end
    end
  end

  assign status = st_q;
  assign irq    = |(st_q & ien);

endmodule

// File: rtl/uart_rx_agefifo.sv
module uart_rx_agefifo
  import rxq_pkg::*;
#(
  parameter  int DEPTH     = 32,
  parameter  int AGE_CHARS = 8,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chr_valid,
  input  logic [CHAR_W-1:0]  chr_data,
  input  logic               chr_frm_err,
  input  logic               chr_par_err,
  input  logic               chr_brk,
  input  logic               char_tick,
  input  logic               rd_en,
  input  logic [CW-1:0]      hiwater,
  input  logic               ien_ready,
  input  logic               ien_age,
  input  logic               ien_brk,
  input  logic               stat_clr_wr,
  input  logic [NSRC-1:0]    stat_clr,
  output logic [ENTRY_W-1:0] rd_word,
  output logic               data_ready,
  output logic [NSRC-1:0]    status,
  output logic               irq
);

  rxq_entry_t    wr_entry;
  rxq_entry_t    rd_entry;
  logic [CW-1:0] fill;
  logic          full;
  logic          empty;
  logic          push_acc;
  logic          pop_acc;
  logic          age_evt;
  logic          hit_level;
  logic          age_restart;
  logic [NSRC-1:0] src_set;
  logic [NSRC-1:0] src_ien;

  always_comb begin
    wr_entry      = '0;
    wr_entry.data = chr_data;
    wr_entry.frm  = chr_frm_err;
    wr_entry.par  = chr_par_err;
    wr_entry.brk  = chr_brk;
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (chr_valid),
    .wr_entry (wr_entry),
    .pop      (rd_en),
    .rd_entry (rd_entry),
    .fill     (fill),
    .full     (full),
    .empty    (empty),
    .push_acc (push_acc),
    .pop_acc  (pop_acc)
  );

  // Any arriving character (kept or dropped) or any read restarts the idle count
  assign age_restart = chr_valid | pop_acc;

  rxq_age #(.LIMIT(AGE_CHARS)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (char_tick),
    .restart (age_restart),
    .active  (~empty),
    .expire  (age_evt)
  );

  assign hit_level = thr_reached(32'(fill), 32'(hiwater));

  always_comb begin
    src_set            = '0;
    src_set[SRC_READY] = hit_level;
    src_set[SRC_AGE]   = age_evt;
    src_set[SRC_BRK]   = chr_valid & chr_brk;
    src_ien            = '0;
    src_ien[SRC_READY] = ien_ready;
    src_ien[SRC_AGE]   = ien_age;
    src_ien[SRC_BRK]   = ien_brk;
  end

  rxq_irq #(.N(NSRC)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (src_set),
    .clr_wr   (stat_clr_wr),
    .clr_mask (stat_clr),
    .ien      (src_ien),
    .status   (status),
    .irq      (irq)
  );

  assign rd_word    = rd_entry;
  assign data_ready = ~empty;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter  int DEPTH = 32,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chr_valid,
  input logic          chr_brk,
  input logic          stat_clr_wr,
  input logic [2:0]    stat_clr,
  input logic [CW-1:0] hiwater,
  input logic [2:0]    status,
  input logic          data_ready,
  input logic [CW-1:0] fill,
  input logic          full,
  input logic          push_acc,
  input logic          pop_acc,
  input logic          age_evt
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && chr_valid && !pop_acc) |=> $stable(fill));

  p_push_shows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> data_ready);

  p_level_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (($past(hiwater) != '0) && ($past(fill) >= $past(hiwater))));

  p_age_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    age_evt |-> (fill != '0));

  p_brk_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && chr_brk) |=> status[2]);

  p_clear_age_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_wr && stat_clr[1] && !age_evt) |=> !status[1]);

endmodule

bind uart_rx_agefifo rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chr_valid   (chr_valid),
  .chr_brk     (chr_brk),
  .stat_clr_wr (stat_clr_wr),
  .stat_clr    (stat_clr),
  .hiwater     (hiwater),
  .status      (status),
  .data_ready  (data_ready),
  .fill        (fill),
  .full        (full),
  .push_acc    (push_acc),
  .pop_acc     (pop_acc),
  .age_evt     (age_evt)
);

// File: tb/tb_uart_rx_agefifo.sv
module tb_uart_rx_agefifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int AGE        = 8;

  logic        clk;
  logic        rst_n;
  logic        chr_valid;
  logic [7:0]  chr_data;
  logic        chr_frm_err;
  logic        chr_par_err;
  logic        chr_brk;
  logic        char_tick;
  logic        rd_en;
  logic [5:0]  hiwater;
  logic        ien_ready;
  logic        ien_age;
  logic        ien_brk;
  logic        stat_clr_wr;
  logic [2:0]  stat_clr;
  logic [11:0] rd_word;
  logic        data_ready;
  logic [2:0]  status;
  logic        irq;

  uart_rx_agefifo #(.DEPTH(DEPTH), .AGE_CHARS(AGE)) dut (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
    .chr_frm_err(chr_frm_err), .chr_par_err(chr_par_err), .chr_brk(chr_brk),
    .char_tick(char_tick), .rd_en(rd_en), .hiwater(hiwater),
    .ien_ready(ien_ready), .ien_age(ien_age), .ien_brk(ien_brk),
    .stat_clr_wr(stat_clr_wr), .stat_clr(stat_clr),
    .rd_word(rd_word), .data_ready(data_ready), .status(status), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int          n_chk  = 0;
  int          n_bad  = 0;
  int          fill_m = 0;
  bit          done   = 0;
  logic [11:0] exp_q[$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Read-word layout: {brk, ovr, par, frm, data}
  function automatic logic [11:0] mk(input logic [7:0] d, input logic f, input logic p, input logic b);
    return {b, 1'b0, p, f, d};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one character, and the expected entry into the scoreboard
  task automatic push(input logic [7:0] d, input logic f, input logic p, input logic b);
    logic [11:0] t;
    @(negedge clk);
    chr_valid = 1'b1; chr_data = d; chr_frm_err = f; chr_par_err = p; chr_brk = b;
    @(negedge clk);
    chr_valid = 1'b0; chr_brk = 1'b0; chr_frm_err = 1'b0; chr_par_err = 1'b0;
    if (fill_m < DEPTH) begin
      exp_q.push_back(mk(d, f, p, b));
      fill_m++;
    end else begin
      t = exp_q.pop_back();
      t[10] = 1'b1;
      exp_q.push_back(t);
    end
  endtask

  // Monitor: compare the shown entry with the scoreboard, then consume it
  task automatic mon_read(input string req);
    logic [11:0] e;
    e = exp_q.pop_front();
    check(req, 32'(rd_word), 32'(e));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    fill_m--;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1'b1;
      @(negedge clk);
      char_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic clr(input logic [2:0] m);
    stat_clr_wr = 1'b1; stat_clr = m;
    @(negedge clk);
    stat_clr_wr = 1'b0; stat_clr = '0;
  endtask

  initial begin
    rst_n = 1'b0; chr_valid = 1'b0; chr_data = '0; chr_frm_err = 1'b0;
    chr_par_err = 1'b0; chr_brk = 1'b0; char_tick = 1'b0; rd_en = 1'b0;
    hiwater = 6'd24; ien_ready = 1'b0; ien_age = 1'b0; ien_brk = 1'b0;
    stat_clr_wr = 1'b0; stat_clr = '0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 data_ready", 32'(data_ready), 0);
    check("R1 status", 32'(status), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 rd_word", 32'(rd_word), 0);

    // Threshold of 4, all enables off
    hiwater = 6'd4;
    push(8'h41, 1'b1, 1'b0, 1'b0);
    check("R4 data_ready one entry", 32'(data_ready), 1);
    push(8'h5A, 1'b0, 1'b1, 1'b0);
    push(8'h00, 1'b1, 1'b1, 1'b0);
    idle(1);
    check("R5 below threshold", 32'(status[0]), 0);
    push(8'hFF, 1'b0, 1'b0, 1'b0);
    idle(1);
    check("R5 threshold reached", 32'(status[0]), 1);
    check("R9 irq masked", 32'(irq), 0);
    ien_ready = 1'b1;
    idle(1);
    check("R9 irq level source", 32'(irq), 1);
    for (int i = 0; i < 4; i++) mon_read("R2 order and fields");
    check("R4 data_ready after drain", 32'(data_ready), 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R2 read while empty word", 32'(rd_word), 0);
    check("R2 read while empty ready", 32'(data_ready), 0);
    check("R5 sticky", 32'(status[0]), 1);
    clr(3'b001);
    check("R8 clear level", 32'(status), 0);
    check("R9 irq after clear", 32'(irq), 0);

    // Aging below a threshold of 24
    hiwater = 6'd24;
    push(8'h31, 1'b0, 1'b0, 1'b0);
    tick(AGE - 1);
    push(8'h32, 1'b0, 1'b0, 1'b0);
    tick(AGE - 1);
    check("R6 restarted by new char", 32'(status[1]), 0);
    tick(1);
    check("R6 expiry on eighth tick", 32'(status[1]), 1);
    check("R9 age source masked", 32'(irq), 0);
    ien_age = 1'b1;
    idle(1);
    check("R9 age source enabled", 32'(irq), 1);
    clr(3'b010);
    check("R8 clear age", 32'(status), 0);
    tick(10);
    check("R6 no refire without restart", 32'(status[1]), 0);
    mon_read("R2 aged entry");
    tick(AGE - 1);
    check("R6 restarted by read", 32'(status[1]), 0);
    mon_read("R2 aged entry");
    tick(10);
    check("R6 idle while empty", 32'(status[1]), 0);
    ien_age = 1'b0; ien_ready = 1'b0;

    // Fill past capacity with the level source switched off
    hiwater = 6'd0;
    for (int i = 0; i < DEPTH + 1; i++)
      push(8'(i * 7 + 3), 1'(i), 1'(i >> 1), 1'b0);
    idle(1);
    check("R5 zero threshold", 32'(status[0]), 0);
    check("R3 full data_ready", 32'(data_ready), 1);
    for (int i = 0; i < DEPTH; i++) mon_read("R3 overrun on newest");
    check("R3 dropped char not stored", 32'(data_ready), 0);

    // Break source alone
    ien_brk = 1'b1;
    push(8'h7E, 1'b1, 1'b0, 1'b1);
    check("R7 break status", 32'(status), 32'h4);
    check("R9 break irq", 32'(irq), 1);
    clr(3'b010);
    check("R8 other bits kept", 32'(status), 32'h4);
    @(negedge clk);
    chr_valid = 1'b1; chr_data = 8'h10; chr_brk = 1'b1;
    stat_clr_wr = 1'b1; stat_clr = 3'b100;
    @(negedge clk);
    chr_valid = 1'b0; chr_brk = 1'b0; stat_clr_wr = 1'b0; stat_clr = '0;
    exp_q.push_back(mk(8'h10, 1'b0, 1'b0, 1'b1));
    fill_m++;
    check("R8 set beats clear", 32'(status[2]), 1);
    clr(3'b100);
    check("R8 clear break", 32'(status), 0);
    check("R9 irq idle", 32'(irq), 0);
    mon_read("R2 break entry");
    mon_read("R2 break entry");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1-bench act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule